// File: doc/BRIEF.md
# Byte-Aliased Register File with Move Execution

This block holds the architectural register state of a small 16-bit processor: eight general registers and four segment registers. A decoded move command updates at most one register per clock. The command gives a destination operand, a source operand or an immediate value, and a size. Two independent combinational read ports let surrounding logic observe any operand at any time.

Byte operands are not separate storage. A byte selector names the low or high half of one of the first four general registers. A byte write merges into its 16-bit host register and leaves the other half as it was.

Operand classes may only be paired in certain ways. A move that breaks a pairing rule is rejected. The block raises an error pulse for it and changes no register.

Top module: `gp_seg_regfile`

## Requirements
- R1: A synchronous active-high `rst` clears all eight general and four segment registers to zero and holds `mov_err` low in the cycle after reset.
- R2: Operand class encoding is 00 byte, 01 general word, 10 segment, 11 reserved. A legal general-word to general-word move copies all 16 bits. It commits at the rising edge where `cmd_valid` is sampled high and shows on the read ports after that edge.
- R3: A byte selector of 3 bits uses bits [1:0] to pick general register 0 to 3 and bit 2 to pick the high half (1) or the low half (0). A byte read returns that half in bits [7:0] with bits [15:8] zero. A byte-to-byte move copies one such half into another.
- R4: A byte write into the high half replaces bits [15:8] of the host register and keeps bits [7:0]. A write into the low half replaces bits [7:0] and keeps bits [15:8].
- R5: A byte move whose source and destination halves lie in the same general register uses the source value from before the write.
- R6: With `cmd_src_imm` high, `cmd_imm_wide` gives the immediate size (1 = 16-bit, 0 = 8-bit). An 8-bit immediate (`cmd_imm[7:0]`) into a byte destination writes only the selected half. A 16-bit immediate into a general word destination writes all 16 bits.
- R7: A general word can move into a segment register, and a segment register can move into a general word. Segment indices 0 to 3 are valid.
- R8: The following moves are illegal: segment to segment, any pairing of byte with general word or segment, an immediate whose size differs from its byte or general word destination, an immediate into a segment register, a reserved class, and a segment index above 3. An illegal move raises `mov_err` for exactly the one cycle after its edge and leaves every register unchanged.
- R9: While `cmd_valid` is low, no register changes and `mov_err` stays low, whatever the other command inputs hold.
- R10: Each read port is combinational. Its data follows a change of its class or index without waiting for a clock edge. The reserved class, and a segment index above 3, read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Move command strobe |
| cmd_dst_cls | input | 2 | Destination operand class |
| cmd_dst_idx | input | 3 | Destination index or byte selector |
| cmd_src_cls | input | 2 | Source operand class (ignored for immediates) |
| cmd_src_idx | input | 3 | Source index or byte selector |
| cmd_src_imm | input | 1 | Source is the immediate value |
| cmd_imm_wide | input | 1 | Immediate size: 1 = 16-bit, 0 = 8-bit |
| cmd_imm | input | 16 | Immediate value |
| rd_a_cls | input | 2 | Read port A operand class |
| rd_a_idx | input | 3 | Read port A index or byte selector |
| rd_a_data | output | 16 | Read port A data |
| rd_b_cls | input | 2 | Read port B operand class |
| rd_b_idx | input | 3 | Read port B index or byte selector |
| rd_b_data | output | 16 | Read port B data |
| mov_err | output | 1 | One-cycle pulse for a rejected move |

## Verification
A corrupted register surfaces on a read port as soon as the read port selects that register, because the read path has no pipeline stage. The bench therefore reads all twelve registers after every command. It also reads byte views after byte writes, so a wrong merge or a wrong half shows up within one cycle of the faulty write. A wrongly accepted illegal move would both alter a register and miss the `mov_err` pulse. That pulse is checked in the cycle right after the command edge, and again one cycle later to confirm it has ended.

// File: rtl/gsr_pkg.sv
package gsr_pkg;

    typedef enum logic [1:0] {
        CLS_BYTE = 2'b00,
        CLS_WORD = 2'b01,
        CLS_SEG  = 2'b10,
        CLS_NONE = 2'b11
    } opnd_cls_e;

endpackage

// File: rtl/gsr_read_mux.sv
module gsr_read_mux
    import gsr_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int GPR_NUM  = 8,
    parameter int SEG_NUM  = 4,
    parameter int BYTE_NUM = 4,
    parameter int IDX_W    = 3
) (
    input  logic [GPR_NUM-1:0][DATA_W-1:0] gpr_i,
    input  logic [SEG_NUM-1:0][DATA_W-1:0] seg_i,
    input  logic [1:0]                     cls_i,
    input  logic [IDX_W-1:0]               idx_i,
    output logic [DATA_W-1:0]              data_o
);
    localparam int HALF_W = DATA_W / 2;
    localparam int BSEL_W = $clog2(BYTE_NUM);

    logic [BSEL_W-1:0] byte_host;
    logic              byte_hi;
    logic [DATA_W-1:0] host_word;

    assign byte_host = idx_i[BSEL_W-1:0];
    assign byte_hi   = idx_i[IDX_W-1];
    assign host_word = gpr_i[byte_host];

    always_comb begin
        data_o = '0;
        unique case (opnd_cls_e'(cls_i))
            CLS_BYTE: data_o = {{HALF_W{1'b0}},
                                byte_hi ? host_word[DATA_W-1:HALF_W]
                                        : host_word[HALF_W-1:0]};
            CLS_WORD: data_o = gpr_i[idx_i];
            CLS_SEG: begin
                if (int'(idx_i) < SEG_NUM)
                    data_o = seg_i[idx_i[$clog2(SEG_NUM)-1:0]];
            end
            default: data_o = '0;
        endcase
    end

endmodule

// File: rtl/gsr_legal.sv
module gsr_legal
    import gsr_pkg::*;
#(
    parameter int SEG_NUM = 4,
    parameter int IDX_W   = 3
) (
    input  logic [1:0]       dst_cls_i,
    input  logic [IDX_W-1:0] dst_idx_i,
    input  logic [1:0]       src_cls_i,
    input  logic [IDX_W-1:0] src_idx_i,
    input  logic             src_imm_i,
    input  logic             imm_wide_i,
    output logic             legal_o
);
    opnd_cls_e dst_c;
    opnd_cls_e src_c;
    logic      dst_seg_ok;
    logic      src_seg_ok;

    assign dst_c      = opnd_cls_e'(dst_cls_i);
    assign src_c      = opnd_cls_e'(src_cls_i);
    assign dst_seg_ok = int'(dst_idx_i) < SEG_NUM;
    assign src_seg_ok = int'(src_idx_i) < SEG_NUM;

    always_comb begin
        legal_o = 1'b0;
        if (src_imm_i) begin
            unique case (dst_c)
                CLS_BYTE: legal_o = !imm_wide_i;
                CLS_WORD: legal_o = imm_wide_i;
                default:  legal_o = 1'b0;
            endcase
        end else begin
            unique case (dst_c)
                CLS_BYTE: legal_o = (src_c == CLS_BYTE);
                CLS_WORD: legal_o = (src_c == CLS_WORD) ||
                                    ((src_c == CLS_SEG) && src_seg_ok);
                CLS_SEG:  legal_o = (src_c == CLS_WORD) && dst_seg_ok;
                default:  legal_o = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/gsr_byte_merge.sv
module gsr_byte_merge #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0]   word_i,
    input  logic [DATA_W/2-1:0] byte_i,
    input  logic                hi_i,
    output logic [DATA_W-1:0]   word_o
);
    localparam int HALF_W = DATA_W / 2;

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic take;
        assign take = (h == 1) ? hi_i : !hi_i;
        assign word_o[h*HALF_W +: HALF_W] = take ? byte_i : word_i[h*HALF_W +: HALF_W];
    end

endmodule

// File: rtl/gp_seg_regfile.sv
module gp_seg_regfile
    import gsr_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int GPR_NUM  = 8,
    parameter int SEG_NUM  = 4,
    parameter int BYTE_NUM = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cmd_valid,
    input  logic [1:0]                   cmd_dst_cls,
    input  logic [$clog2(GPR_NUM)-1:0]   cmd_dst_idx,
    input  logic [1:0]                   cmd_src_cls,
    input  logic [$clog2(GPR_NUM)-1:0]   cmd_src_idx,
    input  logic                         cmd_src_imm,
    input  logic                         cmd_imm_wide,
    input  logic [DATA_W-1:0]            cmd_imm,
    input  logic [1:0]                   rd_a_cls,
    input  logic [$clog2(GPR_NUM)-1:0]   rd_a_idx,
    output logic [DATA_W-1:0]            rd_a_data,
    input  logic [1:0]                   rd_b_cls,
    input  logic [$clog2(GPR_NUM)-1:0]   rd_b_idx,
    output logic [DATA_W-1:0]            rd_b_data,
    output logic                         mov_err
);
    localparam int IDX_W  = $clog2(GPR_NUM);
    localparam int SEG_IW = $clog2(SEG_NUM);
    localparam int BSEL_W = $clog2(BYTE_NUM);
    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        logic [GPR_NUM-1:0][DATA_W-1:0] gpr;
        logic [SEG_NUM-1:0][DATA_W-1:0] seg;
        logic                           err;
    } state_t;

    state_t st_d, st_q;

    logic [DATA_W-1:0] src_rd;
    logic [DATA_W-1:0] src_val;
    logic              legal;
    logic [BSEL_W-1:0] dst_host;
    logic              dst_hi;
    logic [DATA_W-1:0] merged;

    // Read ports
    gsr_read_mux #(
        .DATA_W(DATA_W), .GPR_NUM(GPR_NUM), .SEG_NUM(SEG_NUM),
        .BYTE_NUM(BYTE_NUM), .IDX_W(IDX_W)
    ) u_rd_a (
        .gpr_i(st_q.gpr), .seg_i(st_q.seg),
        .cls_i(rd_a_cls), .idx_i(rd_a_idx), .data_o(rd_a_data)
    );

    gsr_read_mux #(
        .DATA_W(DATA_W), .GPR_NUM(GPR_NUM), .SEG_NUM(SEG_NUM),
        .BYTE_NUM(BYTE_NUM), .IDX_W(IDX_W)
    ) u_rd_b (
        .gpr_i(st_q.gpr), .seg_i(st_q.seg),
        .cls_i(rd_b_cls), .idx_i(rd_b_idx), .data_o(rd_b_data)
    );

    // Move source operand, read from current (pre-write) state
    gsr_read_mux #(
        .DATA_W(DATA_W), .GPR_NUM(GPR_NUM), .SEG_NUM(SEG_NUM),
        .BYTE_NUM(BYTE_NUM), .IDX_W(IDX_W)
    ) u_rd_src (
        .gpr_i(st_q.gpr), .seg_i(st_q.seg),
        .cls_i(cmd_src_cls), .idx_i(cmd_src_idx), .data_o(src_rd)
    );

    gsr_legal #(
        .SEG_NUM(SEG_NUM), .IDX_W(IDX_W)
    ) u_legal (
        .dst_cls_i(cmd_dst_cls), .dst_idx_i(cmd_dst_idx),
        .src_cls_i(cmd_src_cls), .src_idx_i(cmd_src_idx),
        .src_imm_i(cmd_src_imm), .imm_wide_i(cmd_imm_wide),
        .legal_o(legal)
    );

    assign src_val  = cmd_src_imm ? cmd_imm : src_rd;
    assign dst_host = cmd_dst_idx[BSEL_W-1:0];
    assign dst_hi   = cmd_dst_idx[IDX_W-1];

    gsr_byte_merge #(
        .DATA_W(DATA_W)
    ) u_merge (
        .word_i(st_q.gpr[dst_host]), .byte_i(src_val[HALF_W-1:0]),
        .hi_i(dst_hi), .word_o(merged)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (cmd_valid) begin
            if (!legal) begin
                st_d.err = 1'b1;
            end else begin
                unique case (opnd_cls_e'(cmd_dst_cls))
                    CLS_BYTE: st_d.gpr[dst_host] = merged;
                    CLS_WORD: st_d.gpr[cmd_dst_idx] = src_val;
                    CLS_SEG:  st_d.seg[cmd_dst_idx[SEG_IW-1:0]] = src_val;
                    default:  st_d.err = 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign mov_err = st_q.err;

endmodule

// File: rtl/gsr_checker.sv
module gsr_checker (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic [1:0]  rd_a_cls,
    input logic [2:0]  rd_a_idx,
    input logic [15:0] rd_a_data,
    input logic [1:0]  rd_b_cls,
    input logic [2:0]  rd_b_idx,
    input logic [15:0] rd_b_data,
    input logic        mov_err
);
    AST_RESET_NO_ERR: assert property (@(posedge clk)
        rst |=> !mov_err);                                              // R1

    AST_ERR_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
        mov_err |-> $past(cmd_valid));                                  // R8

    AST_IDLE_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> !mov_err);                                       // R9

    AST_ILLEGAL_KEEPS_A: assert property (@(posedge clk) disable iff (rst)
        (mov_err && !$past(rst) && $stable(rd_a_cls) && $stable(rd_a_idx))
            |-> $stable(rd_a_data));                                    // R8

    AST_IDLE_KEEPS_B: assert property (@(posedge clk) disable iff (rst)
        (!$past(cmd_valid) && !$past(rst) && $stable(rd_b_cls) && $stable(rd_b_idx))
            |-> $stable(rd_b_data));                                    // R9

endmodule

bind gp_seg_regfile gsr_checker u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid),
    .rd_a_cls(rd_a_cls), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_cls(rd_b_cls), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .mov_err(mov_err)
);

// File: tb/gp_seg_regfile_tb.sv
module gp_seg_regfile_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_dst_cls = '0;
    logic [2:0]  cmd_dst_idx = '0;
    logic [1:0]  cmd_src_cls = '0;
    logic [2:0]  cmd_src_idx = '0;
    logic        cmd_src_imm = 1'b0;
    logic        cmd_imm_wide = 1'b0;
    logic [15:0] cmd_imm = '0;
    logic [1:0]  rd_a_cls = '0;
    logic [2:0]  rd_a_idx = '0;
    logic [15:0] rd_a_data;
    logic [1:0]  rd_b_cls = '0;
    logic [2:0]  rd_b_idx = '0;
    logic [15:0] rd_b_data;
    logic        mov_err;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gp_seg_regfile u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid),
        .cmd_dst_cls(cmd_dst_cls), .cmd_dst_idx(cmd_dst_idx),
        .cmd_src_cls(cmd_src_cls), .cmd_src_idx(cmd_src_idx),
        .cmd_src_imm(cmd_src_imm), .cmd_imm_wide(cmd_imm_wide), .cmd_imm(cmd_imm),
        .rd_a_cls(rd_a_cls), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_cls(rd_b_cls), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .mov_err(mov_err)
    );

    // Reference state built from the requirements
    logic [15:0] mg [8];
    logic [15:0] ms [4];

    typedef struct {
        logic [1:0]  cls;
        logic [2:0]  idx;
        logic [15:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q [$];

    function automatic logic [15:0] exp_read(logic [1:0] c, logic [2:0] i);
        case (c)
            2'b00:   return {8'h00, i[2] ? mg[i[1:0]][15:8] : mg[i[1:0]][7:0]};
            2'b01:   return mg[i];
            2'b10:   return (i < 3'd4) ? ms[i[1:0]] : 16'h0000;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic bit exp_legal(logic [1:0] dc, logic [2:0] di, logic [1:0] sc,
                                     logic [2:0] si, logic imm, logic wide);
        if (dc == 2'b11) return 0;
        if (dc == 2'b10 && di > 3'd3) return 0;
        if (imm) begin
            if (dc == 2'b00) return !wide;
            if (dc == 2'b01) return wide;
            return 0;
        end
        if (sc == 2'b11) return 0;
        if (sc == 2'b10 && si > 3'd3) return 0;
        return (dc == 2'b00 && sc == 2'b00) || (dc == 2'b01 && sc == 2'b01) ||
               (dc == 2'b10 && sc == 2'b01) || (dc == 2'b01 && sc == 2'b10);
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic push(logic [1:0] c, logic [2:0] i, string tag);
        sb_item_t it;
        it.cls = c; it.idx = i; it.exp = exp_read(c, i); it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic drain();
        wait (sb_q.size() == 0);
        #2;
    endtask

    task automatic push_all(string tag);
        for (int g = 0; g < 8; g++) push(2'b01, 3'(g), tag);
        for (int s = 0; s < 4; s++) push(2'b10, 3'(s), tag);
        drain();
    endtask

    task automatic push_bytes(string tag);
        for (int b = 0; b < 8; b++) push(2'b00, 3'(b), tag);
        drain();
    endtask

    // Monitor: owns read port B, compares against queued expectations
    initial begin
        forever begin
            sb_item_t it;
            wait (sb_q.size() != 0);
            it = sb_q[0];
            rd_b_cls = it.cls;
            rd_b_idx = it.idx;
            #1;
            check(it.tag, rd_b_data, it.exp,
                  $sformatf("read cls=%0d idx=%0d", it.cls, it.idx));
            void'(sb_q.pop_front());
        end
    end

    task automatic do_mov(logic [1:0] dc, logic [2:0] di, logic [1:0] sc, logic [2:0] si,
                          logic imm, logic wide, logic [15:0] iv, string tag);
        bit ok;
        logic [15:0] val;
        ok  = exp_legal(dc, di, sc, si, imm, wide);
        val = imm ? iv : exp_read(sc, si);
        @(negedge clk);
        cmd_dst_cls = dc; cmd_dst_idx = di; cmd_src_cls = sc; cmd_src_idx = si;
        cmd_src_imm = imm; cmd_imm_wide = wide; cmd_imm = iv; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(tag, {15'd0, mov_err}, {15'd0, !ok}, "error flag after edge");
        if (ok) begin
            case (dc)
                2'b00: if (di[2]) mg[di[1:0]][15:8] = val[7:0];
                       else       mg[di[1:0]][7:0]  = val[7:0];
                2'b01: mg[di] = val;
                default: ms[di[1:0]] = val;
            endcase
        end
        push_all(tag);
        @(negedge clk);
        check(tag, {15'd0, mov_err}, 16'd0, "error flag one cycle later");
    endtask

    task automatic clear_model();
        for (int g = 0; g < 8; g++) mg[g] = '0;
        for (int s = 0; s < 4; s++) ms[s] = '0;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    // Driver
    initial begin
        clear_model();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", {15'd0, mov_err}, 16'd0, "error after reset");
        push_all("R1");

        // R6: word immediates
        do_mov(2'b01, 3'd0, 2'b00, 3'd0, 1'b1, 1'b1, 16'h1234, "R6");
        do_mov(2'b01, 3'd3, 2'b00, 3'd0, 1'b1, 1'b1, 16'hBEEF, "R6");
        do_mov(2'b01, 3'd5, 2'b00, 3'd0, 1'b1, 1'b1, 16'hA5C3, "R6");
        // R4/R6: byte immediates into high and low halves
        do_mov(2'b00, 3'd4, 2'b00, 3'd0, 1'b1, 1'b0, 16'hFF77, "R4");
        push_bytes("R4");
        do_mov(2'b00, 3'd3, 2'b00, 3'd0, 1'b1, 1'b0, 16'h0011, "R6");
        push_bytes("R3");
        // R3: byte to byte across registers (gpr3 high -> gpr1 low)
        do_mov(2'b00, 3'd1, 2'b00, 3'd7, 1'b0, 1'b0, 16'h0000, "R3");
        // R5: same-register byte moves
        do_mov(2'b00, 3'd4, 2'b00, 3'd0, 1'b0, 1'b0, 16'h0000, "R5");
        do_mov(2'b00, 3'd3, 2'b00, 3'd3, 1'b0, 1'b0, 16'h0000, "R5");
        // R2: word to word
        do_mov(2'b01, 3'd7, 2'b01, 3'd5, 1'b0, 1'b0, 16'h0000, "R2");
        // R7: general <-> segment
        do_mov(2'b10, 3'd2, 2'b01, 3'd3, 1'b0, 1'b0, 16'h0000, "R7");
        do_mov(2'b10, 3'd3, 2'b01, 3'd7, 1'b0, 1'b0, 16'h0000, "R7");
        do_mov(2'b01, 3'd6, 2'b10, 3'd2, 1'b0, 1'b0, 16'h0000, "R7");

        // R8: illegal pairings
        do_mov(2'b10, 3'd0, 2'b10, 3'd2, 1'b0, 1'b0, 16'h0000, "R8");
        do_mov(2'b00, 3'd1, 2'b01, 3'd5, 1'b0, 1'b0, 16'h0000, "R8");
        do_mov(2'b01, 3'd2, 2'b00, 3'd4, 1'b0, 1'b0, 16'h0000, "R8");
        do_mov(2'b10, 3'd1, 2'b00, 3'd0, 1'b0, 1'b0, 16'h0000, "R8");
        do_mov(2'b00, 3'd2, 2'b10, 3'd2, 1'b0, 1'b0, 16'h0000, "R8");
        do_mov(2'b01, 3'd4, 2'b00, 3'd0, 1'b1, 1'b0, 16'h5A5A, "R8");
        do_mov(2'b00, 3'd0, 2'b00, 3'd0, 1'b1, 1'b1, 16'h5A5A, "R8");
        do_mov(2'b10, 3'd0, 2'b00, 3'd0, 1'b1, 1'b1, 16'h5A5A, "R8");
        do_mov(2'b11, 3'd0, 2'b01, 3'd0, 1'b0, 1'b0, 16'h0000, "R8");
        do_mov(2'b01, 3'd0, 2'b11, 3'd0, 1'b0, 1'b0, 16'h0000, "R8");
        do_mov(2'b10, 3'd5, 2'b01, 3'd0, 1'b0, 1'b0, 16'h0000, "R8");
        do_mov(2'b01, 3'd1, 2'b10, 3'd6, 1'b0, 1'b0, 16'h0000, "R8");

        // R9: strobe low with a legal command on the other inputs
        @(negedge clk);
        cmd_dst_cls = 2'b01; cmd_dst_idx = 3'd1; cmd_src_imm = 1'b1;
        cmd_imm_wide = 1'b1; cmd_imm = 16'hFFFF; cmd_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R9", {15'd0, mov_err}, 16'd0, "error while idle");
        end
        push_all("R9");

        // R10: combinational read on port A
        rd_a_cls = 2'b01; rd_a_idx = 3'd5; #1;
        check("R10", rd_a_data, exp_read(2'b01, 3'd5), "port A word 5");
        rd_a_idx = 3'd0; #1;
        check("R10", rd_a_data, exp_read(2'b01, 3'd0), "port A word 0");
        rd_a_cls = 2'b00; rd_a_idx = 3'd7; #1;
        check("R10", rd_a_data, exp_read(2'b00, 3'd7), "port A byte 7");
        rd_a_cls = 2'b10; rd_a_idx = 3'd6; #1;
        check("R10", rd_a_data, 16'h0000, "port A segment index 6");
        rd_a_cls = 2'b11; rd_a_idx = 3'd0; #1;
        check("R10", rd_a_data, 16'h0000, "port A reserved class");

        // R1: reset again after traffic
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        clear_model();
        @(negedge clk);
        check("R1", {15'd0, mov_err}, 16'd0, "error after second reset");
        push_all("R1");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule